// File: doc/BRIEF.md
# Serial Audio to Offset-Binary Converter Formatter

The block takes a standard I2S stream (bit clock, word select, serial data) and reformats it for a 14-bit, two-channel resistor-ladder converter. That converter expects offset-binary words shifted in on two separate data lines under one shared clock, followed by a load strobe. Every register runs from a fast master clock. The three I2S inputs pass through a synchronizer, and the block finds the bit-clock edges by comparing the synchronized level with its value one master cycle earlier.

In each channel slot the capture machine records the 14 most significant bits and ignores the rest of the slot. It flips the sign bit so that two's complement becomes offset binary. It keeps the left word until the right word is complete and then passes both to the serializer machine together. The serializer shifts the two words out MSB first and side by side. Its output clock is the inverted bit clock, and it runs for exactly 14 bits. After that the clock is held low and a load pulse one bit period long is issued, once per word-select period.

Capture machine states are `CAP_HUNT` (waiting for a word-select change) and `CAP_TAKE` (gathering sample bits). A word-select change moves the machine from HUNT to TAKE. The fourteenth bit moves it back to HUNT. Serializer states are `SER_IDLE`, `SER_SHIFT` and `SER_LATCH`. IDLE goes to SHIFT on the first bit-clock rise after a word pair is ready. SHIFT goes to LATCH on the rise that follows the fourteenth presented bit. LATCH goes to IDLE on the next rise.

Top module: `i2s_ob_formatter`

## Requirements
- R1: A frame has 32 bit clocks per channel. `ws_in` low marks the left channel. A sample's MSB is the data bit sampled on the second rising `bck_in` edge after the word-select change.
- R2: Only the top 14 bits of each sample reach the outputs. The 18 lower bits have no effect on the shifted words.
- R3: Each output word is offset binary: the sample's bit 31 is inverted and bits 30..18 are passed unchanged.
- R4: The left word appears on `conv_data_l` and the right word on `conv_data_r`, both MSB first and bit-aligned. Both words come from the same input frame.
- R5: `conv_clk` equals the inverted synchronized bit clock while the words are shifted. It gives exactly 14 rising edges per frame and stays low at all other times. Data changes only while `conv_clk` is low.
- R6: `conv_load` pulses exactly once per frame, after the 14th rising edge of `conv_clk`. It stays high for one bit-clock period, and `conv_clk` remains low for the whole pulse.
- R7: While `rst_n` is low, all four outputs are low.
- R8: All state is clocked by `clk`. The inputs are synchronized, and `clk` must run at least 4 times faster than `bck_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, at least 4x the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bck_in | input | 1 | I2S bit clock |
| ws_in | input | 1 | I2S word select, low = left |
| sd_in | input | 1 | I2S serial data, two's complement, MSB first |
| conv_clk | output | 1 | Gated output bit clock to the converter |
| conv_data_l | output | 1 | Left offset-binary data, MSB first |
| conv_data_r | output | 1 | Right offset-binary data, MSB first |
| conv_load | output | 1 | Load strobe, one bit period per frame |

## Verification
The assertions assume that `bck_in` stays high and low for at least two master cycles each, so that two synchronized rises never fall on adjacent cycles. They also assume that word select and data change only near the falling edge of the bit clock, so that each word pair is shifted out and latched well before the next right word ends. The bench produces the bit clock with a period of 8 master cycles and changes `ws_in` and `sd_in` only at its falling edge. It also lets every right slot run its full 32 bits, which keeps the stimulus inside these limits.

// File: rtl/i2sob_pkg.sv
package i2sob_pkg;

    typedef enum logic {
        CAP_HUNT,
        CAP_TAKE
    } cap_state_t;

    typedef enum logic [1:0] {
        SER_IDLE,
        SER_SHIFT,
        SER_LATCH
    } ser_state_t;

endpackage

// File: rtl/i2sob_sync.sv
module i2sob_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);

    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= '0;
        else        pipe[0] <= d_in;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[g] <= '0;
            else        pipe[g] <= pipe[g-1];
        end
    end

    assign q_out = pipe[STAGES-1];

endmodule

// File: rtl/i2sob_capture.sv
module i2sob_capture
    import i2sob_pkg::*;
#(
    parameter int SAMPLE_W = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bck_rise,
    input  logic                ws,
    input  logic                sd,
    output logic                pair_valid,
    output logic [SAMPLE_W-1:0] left_word,
    output logic [SAMPLE_W-1:0] right_word
);

    localparam int CW = $clog2(SAMPLE_W + 1);
    localparam logic [SAMPLE_W-1:0] SIGN_FLIP = {1'b1, {(SAMPLE_W-1){1'b0}}};

    cap_state_t          state, state_n;
    logic                ws_prev;
    logic                chan;
    logic [CW-1:0]       cnt;
    logic [SAMPLE_W-1:0] sh;
    logic                left_ok;
    logic                last_bit;
    logic [SAMPLE_W-1:0] done_word;

    assign last_bit  = (state == CAP_TAKE) && bck_rise && (ws == ws_prev)
                       && (cnt == CW'(SAMPLE_W - 1));
    assign done_word = {sh[SAMPLE_W-2:0], sd} ^ SIGN_FLIP;

    always_comb begin
        state_n = state;
        unique case (state)
            CAP_HUNT: if (bck_rise && ws != ws_prev) state_n = CAP_TAKE;
            CAP_TAKE: if (last_bit)                  state_n = CAP_HUNT;
            default:                                 state_n = CAP_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CAP_HUNT;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ws_prev    <= 1'b1;
            chan       <= 1'b1;
            cnt        <= '0;
            sh         <= '0;
            left_ok    <= 1'b0;
            left_word  <= '0;
            right_word <= '0;
            pair_valid <= 1'b0;
        end else begin
            pair_valid <= 1'b0;
            if (bck_rise) begin
                ws_prev <= ws;
                if (ws != ws_prev) begin
                    chan <= ws;
                    cnt  <= '0;
                end else if (state == CAP_TAKE) begin
                    sh  <= {sh[SAMPLE_W-2:0], sd};
                    cnt <= cnt + 1'b1;
                    if (last_bit) begin
                        if (!chan) begin
                            left_word <= done_word;
                            left_ok   <= 1'b1;
                        end else if (left_ok) begin
                            right_word <= done_word;
                            pair_valid <= 1'b1;
                            left_ok    <= 1'b0;
                        end
                    end
                end
            end
        end
    end

    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CAP_TAKE) |-> (cnt < CW'(SAMPLE_W)));

    a_r4_pair_after_left: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> ($past(left_ok) && !left_ok));

endmodule

// File: rtl/i2sob_serializer.sv
module i2sob_serializer
    import i2sob_pkg::*;
#(
    parameter int SAMPLE_W = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bck_rise,
    input  logic                bck_lvl,
    input  logic                pair_valid,
    input  logic [SAMPLE_W-1:0] left_word,
    input  logic [SAMPLE_W-1:0] right_word,
    output logic                conv_clk,
    output logic                conv_data_l,
    output logic                conv_data_r,
    output logic                conv_load
);

    localparam int CW = $clog2(SAMPLE_W + 1);

    ser_state_t          state, state_n;
    logic                pending;
    logic [CW-1:0]       cnt;
    logic [SAMPLE_W-1:0] sr_l, sr_r;

    always_comb begin
        state_n = state;
        unique case (state)
            SER_IDLE:  if (bck_rise && pending)                     state_n = SER_SHIFT;
            SER_SHIFT: if (bck_rise && cnt == CW'(SAMPLE_W - 1))    state_n = SER_LATCH;
            SER_LATCH: if (bck_rise)                                state_n = SER_IDLE;
            default:                                                state_n = SER_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SER_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending   <= 1'b0;
            cnt       <= '0;
            sr_l      <= '0;
            sr_r      <= '0;
            conv_clk  <= 1'b0;
            conv_load <= 1'b0;
        end else begin
            if (pair_valid)
                pending <= 1'b1;
            else if (state == SER_IDLE && state_n == SER_SHIFT)
                pending <= 1'b0;

            if (state == SER_IDLE && state_n == SER_SHIFT) begin
                sr_l <= left_word;
                sr_r <= right_word;
                cnt  <= '0;
            end else if (state == SER_SHIFT && state_n == SER_SHIFT && bck_rise) begin
                sr_l <= {sr_l[SAMPLE_W-2:0], 1'b0};
                sr_r <= {sr_r[SAMPLE_W-2:0], 1'b0};
                cnt  <= cnt + 1'b1;
            end

            conv_clk  <= (state_n == SER_SHIFT) && !bck_lvl;
            conv_load <= (state_n == SER_LATCH);
        end
    end

    assign conv_data_l = sr_l[SAMPLE_W-1];
    assign conv_data_r = sr_r[SAMPLE_W-1];

    a_r6_quiet_clk_in_load: assert property (@(posedge clk) disable iff (!rst_n)
        conv_load |-> !conv_clk);

    a_r6_load_holds: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_load) |=> conv_load);

    a_r5_idle_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SER_IDLE) |-> !conv_clk);

    a_r5_bit_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SER_SHIFT) |-> (cnt < CW'(SAMPLE_W)));

    a_r5_data_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_clk && $past(conv_clk)) |-> ($stable(conv_data_l) && $stable(conv_data_r)));

endmodule

// File: rtl/i2s_ob_formatter.sv
module i2s_ob_formatter #(
    parameter int SAMPLE_W    = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bck_in,
    input  logic ws_in,
    input  logic sd_in,
    output logic conv_clk,
    output logic conv_data_l,
    output logic conv_data_r,
    output logic conv_load
);

    logic [2:0]          sync_q;
    logic                bck_s, ws_s, sd_s;
    logic                bck_d;
    logic                bck_rise;
    logic                pair_valid;
    logic [SAMPLE_W-1:0] left_word, right_word;

    i2sob_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({bck_in, ws_in, sd_in}),
        .q_out (sync_q)
    );

    assign {bck_s, ws_s, sd_s} = sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bck_d <= 1'b0;
        else        bck_d <= bck_s;
    end

    assign bck_rise = bck_s && !bck_d;

    i2sob_capture #(.SAMPLE_W(SAMPLE_W)) i_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .bck_rise   (bck_rise),
        .ws         (ws_s),
        .sd         (sd_s),
        .pair_valid (pair_valid),
        .left_word  (left_word),
        .right_word (right_word)
    );

    i2sob_serializer #(.SAMPLE_W(SAMPLE_W)) i_serializer (
        .clk         (clk),
        .rst_n       (rst_n),
        .bck_rise    (bck_rise),
        .bck_lvl     (bck_s),
        .pair_valid  (pair_valid),
        .left_word   (left_word),
        .right_word  (right_word),
        .conv_clk    (conv_clk),
        .conv_data_l (conv_data_l),
        .conv_data_r (conv_data_r),
        .conv_load   (conv_load)
    );

    a_r8_rise_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        bck_rise |=> !bck_rise);

endmodule

// File: tb/test_i2s_ob_formatter.sv
`timescale 1ns/1ps
module test_i2s_ob_formatter;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bck_in = 1'b0, ws_in = 1'b1, sd_in = 1'b0;
    logic conv_clk, conv_data_l, conv_data_r, conv_load;

    int n_checks = 0;
    int n_fails  = 0;
    int n_loads  = 0;
    int n_frames = 0;
    logic [27:0] exp_q [$];
    logic        prev_lsb = 1'b0;
    bit          mon_on = 1'b0;

    always #2.5 clk = ~clk;

    i2s_ob_formatter i_i2s_ob_formatter (
        .clk(clk), .rst_n(rst_n), .bck_in(bck_in), .ws_in(ws_in), .sd_in(sd_in),
        .conv_clk(conv_clk), .conv_data_l(conv_data_l),
        .conv_data_r(conv_data_r), .conv_load(conv_load)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one bit clock period = 8 master cycles; ws/sd change at the falling edge
    task automatic drive_bit(input logic ws, input logic sd);
        @(negedge clk);
        bck_in = 1'b0; ws_in = ws; sd_in = sd;
        repeat (4) @(negedge clk);
        bck_in = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [13:0] to_ob(input logic [31:0] s);
        return {~s[31], s[30:18]};
    endfunction

    // R1: slot bit 0 carries previous LSB, MSB follows one bit later
    task automatic send_frame(input logic [31:0] l, input logic [31:0] r);
        exp_q.push_back({to_ob(l), to_ob(r)});
        n_frames++;
        for (int j = 0; j < 32; j++) drive_bit(1'b0, (j == 0) ? prev_lsb : l[32-j]);
        prev_lsb = l[0];
        for (int j = 0; j < 32; j++) drive_bit(1'b1, (j == 0) ? prev_lsb : r[32-j]);
        prev_lsb = r[0];
    endtask

    // monitor: collects shifted bits at conv_clk rises, compares at each load
    logic [13:0] acc_l = '0, acc_r = '0;
    int   nbits = 0, load_w = 0;
    logic clk_p = 1'b0, load_p = 1'b0;

    always @(negedge clk) begin
        if (mon_on) begin
            if (conv_clk && !clk_p) begin
                acc_l = {acc_l[12:0], conv_data_l};
                acc_r = {acc_r[12:0], conv_data_r};
                nbits++;
            end
            if (conv_load && conv_clk) check("R6 clk low during load", 32'(conv_clk), 32'd0);
            if (conv_load) load_w++;
            if (conv_load && !load_p) begin
                n_loads++;
                check("R5 14 clock edges before load", nbits, 14);
                if (exp_q.size() == 0) begin
                    check("R6 unexpected load", 32'd1, 32'd0);
                end else begin
                    logic [27:0] e;
                    e = exp_q.pop_front();
                    check("R2 R3 R4 left word", 32'(acc_l), 32'(e[27:14]));
                    check("R2 R3 R4 right word", 32'(acc_r), 32'(e[13:0]));
                end
                nbits = 0;
            end
            if (!conv_load && load_p) begin
                check("R6 load width one bit period", load_w, 8);
                load_w = 0;
            end
            clk_p  = conv_clk;
            load_p = conv_load;
        end
    end

    initial begin
        repeat (6) @(negedge clk);
        check("R7 reset conv_clk",  32'(conv_clk), 32'd0);
        check("R7 reset data_l",    32'(conv_data_l), 32'd0);
        check("R7 reset data_r",    32'(conv_data_r), 32'd0);
        check("R7 reset conv_load", 32'(conv_load), 32'd0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        for (int k = 0; k < 4; k++) drive_bit(1'b1, 1'b0);
        send_frame(32'h0000_0000, 32'h0000_0000);
        send_frame(32'h7FFF_FFFF, 32'h8000_0000);
        send_frame(32'hFFFF_FFFF, 32'h0000_0001);
        send_frame(32'h5555_5555, 32'hAAAA_AAAA);
        // R2: same top 14 bits, different discarded low bits
        send_frame(32'h1234_0000, 32'hC003_FFFF);
        send_frame(32'h1237_FFFF, 32'hC000_0000);
        for (int i = 1; i <= 6; i++)
            send_frame(32'h9E37_79B9 * i, 32'h85EB_CA6B * (i + 3));
        for (int k = 0; k < 40; k++) drive_bit(1'b1, 1'b0);
        check("R6 one load per frame", n_loads, n_frames);
        check("R4 all frames delivered", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R8 watchdog expired: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule